// File: doc/BRIEF.md
# Accumulator Bit Manipulation Unit

This block is the bit-level datapath that sits beside a pair of 36-bit main accumulators. One operation per clock is issued through a 4-bit code. The operation names a main accumulator, an auxiliary accumulator and one of four 16-bit control registers. The unit supports:

- barrel shifts, logical or arithmetic, in either direction;
- normalization, which strips redundant sign bits and reports how far it shifted;
- extraction and insertion of a bit field described by the selected control register;
- a single-cycle exchange between a main accumulator and an auxiliary one.

Field insertion and extraction make it cheap to pack several short words into one 16-bit word and to unpack them again. The control registers also serve as plain general-purpose storage. The value written back to the addressed accumulator appears on `res` one clock after issue. Zero and negative flags follow the operations that compute data.

Operation codes are: 0 no-op, 1 load, 2 logical shift, 3 arithmetic shift, 4 normalize, 5 extract, 6 insert, 7 swap, 8 control-register write. Codes 9 to 15 behave as the no-op.

Top module: `acc_bitmanip`

## Requirements
- R1: With `op_valid` high and code 1, the addressed main accumulator takes `din`. `res` shows `din` after the next rising edge.
- R2: Code 2 shifts the addressed accumulator by the signed 6-bit amount in bits [5:0] of the selected control register. A positive amount shifts left and a negative one shifts right. Vacated bits fill with zeros; an amount of -32 shifts right by 32.
- R3: Code 3 shifts the same way as code 2, except that a right shift fills vacated bits with copies of bit 35.
- R4: Code 4 shifts the accumulator left until bit 35 differs from bit 34, and produces the count as an exponent. The exponent appears on `exp_o` and is written, zero-extended, into the selected control register. An all-zero or all-one accumulator gives an exponent of 35, and a zero result sets `flag_z`.
- R5: Code 5 replaces the accumulator with its field of width bits [13:8] starting at offset bits [5:0] of the control register. The field is right-justified with zeros above it, and field bits beyond bit 35 read as zero.
- R6: Code 6 copies the low `width` bits of the other main accumulator into the addressed one at the given offset. All bits outside the field, including any that would fall beyond bit 35, keep their values.
- R7: For codes 5 and 6, a width of 0 leaves the accumulator and both flags unchanged.
- R8: Code 7 exchanges the addressed main accumulator with the addressed auxiliary accumulator in one clock.
- R9: Code 8 writes `din[15:0]` into the selected control register. `ctl_rd` always shows the register chosen by `ctl_sel`, without a clock of delay.
- R10: Codes 2 to 6 (when they act) set `flag_z` to result == 0 and `flag_n` to bit 35 of the result. Codes 0, 1, 7, 8 and the unused codes leave both flags unchanged, and the unused codes also leave every register unchanged.
- R11: After reset, all accumulators, control registers, `res`, `exp_o` and both flags are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation present this cycle |
| op | input | 4 | Operation code |
| acc_sel | input | 1 | Main accumulator addressed |
| aux_sel | input | 1 | Auxiliary accumulator addressed |
| ctl_sel | input | 2 | Control register addressed |
| din | input | 36 | Load data; low 16 bits for control writes |
| res | output | 36 | Value written back to the addressed accumulator |
| flag_z | output | 1 | Result-zero flag |
| flag_n | output | 1 | Result-negative flag |
| exp_o | output | 6 | Exponent from the last normalize |
| ctl_rd | output | 16 | Contents of the selected control register |

## Verification
The shifter is tried with positive, negative and extreme amounts on accumulators with bit 35 set and clear. This separates the logical and arithmetic fills and shows whether the sign of the amount picks the direction. Normalization is fed a small positive value, a negative value, zero and all ones, which exposes off-by-one counts and the two saturating cases. Field operations run with an interior field, a zero width, an oversized width and an offset that spills past bit 35, so that mask and clipping errors show up. A long random stream of mixed operations, compared on every clock against the bench model, catches mistakes in accumulator selection, swap direction and flag holding.

// File: rtl/bmu_pkg.sv
package bmu_pkg;
    localparam int ACC_W   = 36;
    localparam int CTL_W   = 16;
    localparam int NUM_CTL = 4;
    localparam int NUM_AUX = 2;
    localparam int AMT_W   = 6;
    localparam int AMT_LSB = 0;
    localparam int WID_LSB = 8;
    localparam int OP_W    = 4;
    localparam int EXP_W   = $clog2(ACC_W);

    typedef enum logic [OP_W-1:0] {
        OP_NOP  = 4'd0,
        OP_LOAD = 4'd1,
        OP_SHL  = 4'd2,
        OP_SHA  = 4'd3,
        OP_NORM = 4'd4,
        OP_EXT  = 4'd5,
        OP_INS  = 4'd6,
        OP_SWAP = 4'd7,
        OP_CTLW = 4'd8
    } op_t;
endpackage

// File: rtl/bmu_shifter.sv
module bmu_shifter #(
    parameter int ACC_W = 36,
    parameter int AMT_W = 6
) (
    input  logic [ACC_W-1:0] a,
    input  logic [AMT_W-1:0] amt,
    input  logic             arith,
    output logic [ACC_W-1:0] y
);
    logic [AMT_W-1:0] mag;

    always_comb begin
        // magnitude of a negative amount; -2^(AMT_W-1) maps to 2^(AMT_W-1)
        mag = ~amt + AMT_W'(1);
        if (!amt[AMT_W-1]) begin
            y = a << amt;
        end else if (arith) begin
            y = $unsigned($signed(a) >>> mag);
        end else begin
            y = a >> mag;
        end
    end
endmodule

// File: rtl/bmu_normalizer.sv
module bmu_normalizer #(
    parameter int ACC_W = 36,
    parameter int EXP_W = 6
) (
    input  logic [ACC_W-1:0] a,
    output logic [ACC_W-1:0] y,
    output logic [EXP_W-1:0] expo
);
    logic done;

    always_comb begin
        expo = '0;
        done = 1'b0;
        // count leading bits below the sign that repeat the sign
        for (int i = ACC_W - 2; i >= 0; i--) begin
            if (!done && (a[i] == a[ACC_W-1])) begin
                expo = expo + EXP_W'(1);
            end else begin
                done = 1'b1;
            end
        end
        y = a << expo;
    end
endmodule

// File: rtl/bmu_field.sv
module bmu_field #(
    parameter int ACC_W = 36,
    parameter int FLD_W = 6
) (
    input  logic [ACC_W-1:0] a,
    input  logic [ACC_W-1:0] src,
    input  logic [FLD_W-1:0] width,
    input  logic [FLD_W-1:0] offset,
    output logic [ACC_W-1:0] ext_y,
    output logic [ACC_W-1:0] ins_y
);
    logic [ACC_W-1:0] mask;
    logic [ACC_W-1:0] place;

    always_comb begin
        // widths of ACC_W or more shift every one out, giving a full mask
        mask  = ~({ACC_W{1'b1}} << width);
        place = mask << offset;
        ext_y = (a >> offset) & mask;
        ins_y = (a & ~place) | ((src & mask) << offset);
    end
endmodule

// File: rtl/acc_bitmanip.sv
module acc_bitmanip
    import bmu_pkg::*;
#(
    parameter int P_ACC_W   = ACC_W,
    parameter int P_CTL_W   = CTL_W,
    parameter int P_NUM_CTL = NUM_CTL,
    parameter int P_NUM_AUX = NUM_AUX
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          op_valid,
    input  logic [OP_W-1:0]               op,
    input  logic                          acc_sel,
    input  logic [$clog2(P_NUM_AUX)-1:0]  aux_sel,
    input  logic [$clog2(P_NUM_CTL)-1:0]  ctl_sel,
    input  logic [P_ACC_W-1:0]            din,
    output logic [P_ACC_W-1:0]            res,
    output logic                          flag_z,
    output logic                          flag_n,
    output logic [EXP_W-1:0]              exp_o,
    output logic [P_CTL_W-1:0]            ctl_rd
);
    localparam int NUM_MAIN = 2;

    op_t                 op_c;
    logic [P_ACC_W-1:0]  acc_q [NUM_MAIN];
    logic [P_ACC_W-1:0]  aux_q [P_NUM_AUX];
    logic [P_CTL_W-1:0]  ctl_q [P_NUM_CTL];

    logic [P_ACC_W-1:0]  cur, oth;
    logic [AMT_W-1:0]    amt, fld_w, fld_o;
    logic [P_ACC_W-1:0]  sh_y, nrm_y, ext_y, ins_y;
    logic [EXP_W-1:0]    nrm_exp;

    logic                wr_acc, wr_aux, wr_ctl, wr_exp, upd_flg;
    logic [P_ACC_W-1:0]  acc_nx;
    logic [P_CTL_W-1:0]  ctl_nx;

    assign op_c   = op_t'(op);
    assign cur    = acc_q[acc_sel];
    assign oth    = acc_q[~acc_sel];
    assign amt    = ctl_q[ctl_sel][AMT_LSB +: AMT_W];
    assign fld_o  = ctl_q[ctl_sel][AMT_LSB +: AMT_W];
    assign fld_w  = ctl_q[ctl_sel][WID_LSB +: AMT_W];
    assign ctl_rd = ctl_q[ctl_sel];

    bmu_shifter #(.ACC_W(P_ACC_W), .AMT_W(AMT_W)) u_shift (
        .a     (cur),
        .amt   (amt),
        .arith (op_c == OP_SHA),
        .y     (sh_y)
    );

    bmu_normalizer #(.ACC_W(P_ACC_W), .EXP_W(EXP_W)) u_norm (
        .a    (cur),
        .y    (nrm_y),
        .expo (nrm_exp)
    );

    bmu_field #(.ACC_W(P_ACC_W), .FLD_W(AMT_W)) u_field (
        .a      (cur),
        .src    (oth),
        .width  (fld_w),
        .offset (fld_o),
        .ext_y  (ext_y),
        .ins_y  (ins_y)
    );

    // operation decode: what to write back this cycle
    always_comb begin
        wr_acc  = 1'b0;
        wr_aux  = 1'b0;
        wr_ctl  = 1'b0;
        wr_exp  = 1'b0;
        upd_flg = 1'b0;
        acc_nx  = cur;
        ctl_nx  = ctl_q[ctl_sel];
        unique case (op_c)
            OP_LOAD: begin
                wr_acc = 1'b1;
                acc_nx = din;
            end
            OP_SHL, OP_SHA: begin
                wr_acc  = 1'b1;
                upd_flg = 1'b1;
                acc_nx  = sh_y;
            end
            OP_NORM: begin
                wr_acc  = 1'b1;
                upd_flg = 1'b1;
                wr_ctl  = 1'b1;
                wr_exp  = 1'b1;
                acc_nx  = nrm_y;
                ctl_nx  = P_CTL_W'(nrm_exp);
            end
            OP_EXT: begin
                if (fld_w != '0) begin
                    wr_acc  = 1'b1;
                    upd_flg = 1'b1;
                    acc_nx  = ext_y;
                end
            end
            OP_INS: begin
                if (fld_w != '0) begin
                    wr_acc  = 1'b1;
                    upd_flg = 1'b1;
                    acc_nx  = ins_y;
                end
            end
            OP_SWAP: begin
                wr_acc = 1'b1;
                wr_aux = 1'b1;
                acc_nx = aux_q[aux_sel];
            end
            OP_CTLW: begin
                wr_ctl = 1'b1;
                ctl_nx = din[P_CTL_W-1:0];
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_MAIN; i++)  acc_q[i] <= '0;
            for (int i = 0; i < P_NUM_AUX; i++) aux_q[i] <= '0;
            for (int i = 0; i < P_NUM_CTL; i++) ctl_q[i] <= '0;
            res    <= '0;
            flag_z <= 1'b0;
            flag_n <= 1'b0;
            exp_o  <= '0;
        end else if (op_valid) begin
            if (wr_acc) acc_q[acc_sel] <= acc_nx;
            if (wr_aux) aux_q[aux_sel] <= cur;
            if (wr_ctl) ctl_q[ctl_sel] <= ctl_nx;
            if (wr_exp) exp_o <= nrm_exp;
            if (upd_flg) begin
                flag_z <= (acc_nx == '0);
                flag_n <= acc_nx[P_ACC_W-1];
            end
            res <= acc_nx;
        end
    end
endmodule

// File: rtl/acc_bitmanip_chk.sv
module acc_bitmanip_chk
    import bmu_pkg::*;
(
    input logic                        clk,
    input logic                        rst_n,
    input logic                        op_valid,
    input logic [OP_W-1:0]             op,
    input logic [$clog2(NUM_CTL)-1:0]  ctl_sel,
    input logic [ACC_W-1:0]            din,
    input logic [ACC_W-1:0]            res,
    input logic                        flag_z,
    input logic                        flag_n,
    input logic [EXP_W-1:0]            exp_o,
    input logic [CTL_W-1:0]            ctl_rd
);
    assert_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OP_LOAD) |=> (res == $past(din)));

    assert_norm_shape_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OP_NORM) |=> ((res == '0) || (res[ACC_W-1] != res[ACC_W-2])));

    assert_norm_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OP_NORM) |=> ((res != '0) || (flag_z && exp_o == EXP_W'(ACC_W - 1))));

    assert_norm_ctl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OP_NORM) |=> ((ctl_sel != $past(ctl_sel)) || (ctl_rd == CTL_W'(exp_o))));

    assert_ext_zero_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OP_EXT && ctl_rd[WID_LSB +: AMT_W] != '0
                  && ctl_rd[WID_LSB +: AMT_W] < AMT_W'(ACC_W))
        |=> ((res >> $past(ctl_rd[WID_LSB +: AMT_W])) == '0));

    assert_width0_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op == OP_EXT || op == OP_INS) && ctl_rd[WID_LSB +: AMT_W] == '0)
        |=> ($stable(flag_z) && $stable(flag_n)));

    assert_ctl_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OP_CTLW)
        |=> ((ctl_sel != $past(ctl_sel)) || (ctl_rd == $past(din[CTL_W-1:0]))));

    assert_flag_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op == OP_NOP || op == OP_LOAD || op == OP_SWAP || op == OP_CTLW || op > OP_CTLW))
        |=> ($stable(flag_z) && $stable(flag_n)));

    assert_flag_value_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op == OP_SHL || op == OP_SHA || op == OP_NORM))
        |=> ((flag_z == (res == '0)) && (flag_n == res[ACC_W-1])));
endmodule

bind acc_bitmanip acc_bitmanip_chk u_chk (.*);

// File: tb/sim_acc_bitmanip.sv
`timescale 1ns/1ps
module sim_acc_bitmanip;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op = '0;
    logic        acc_sel = 1'b0;
    logic        aux_sel = 1'b0;
    logic [1:0]  ctl_sel = '0;
    logic [35:0] din = '0;
    logic [35:0] res;
    logic        flag_z, flag_n;
    logic [5:0]  exp_o;
    logic [15:0] ctl_rd;

    int checks = 0;
    int errors = 0;

    // reference state
    logic [35:0] macc [2];
    logic [35:0] maux [2];
    logic [15:0] mctl [4];
    logic [35:0] mres;
    logic        mz, mn;
    logic [5:0]  mexp;
    string       cur_tag = "R11";
    logic [1:0]  cur_c = '0;

    always #4 clk = ~clk;

    acc_bitmanip u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op(op),
        .acc_sel(acc_sel), .aux_sel(aux_sel), .ctl_sel(ctl_sel), .din(din),
        .res(res), .flag_z(flag_z), .flag_n(flag_n), .exp_o(exp_o), .ctl_rd(ctl_rd)
    );

    task automatic check(input string tag, input string what,
                         input logic [35:0] act, input logic [35:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", tag, what, act, expv);
        end
    endtask

    task automatic compare_all();
        check(cur_tag, "res",    res,            mres);
        check(cur_tag, "flag_z", 36'(flag_z),    36'(mz));
        check(cur_tag, "flag_n", 36'(flag_n),    36'(mn));
        check(cur_tag, "exp_o",  36'(exp_o),     36'(mexp));
        check(cur_tag, "ctl_rd", 36'(ctl_rd),    36'(mctl[cur_c]));
    endtask

    function automatic logic [35:0] ref_shift(input logic [35:0] v, input logic [5:0] amt,
                                             input bit arith);
        logic [35:0] o;
        int s;
        s = amt[5] ? int'(amt) - 64 : int'(amt);
        for (int i = 0; i < 36; i++) begin
            if (s >= 0) o[i] = (i - s >= 0) ? v[i - s] : 1'b0;
            else        o[i] = (i - s < 36) ? v[i - s] : (arith ? v[35] : 1'b0);
        end
        return o;
    endfunction

    function automatic int ref_norm(input logic [35:0] v);
        int n = 0;
        while (n < 35 && v[34 - n] == v[35]) n++;
        return n;
    endfunction

    function automatic logic [35:0] ref_ext(input logic [35:0] v, input int w, input int off);
        logic [35:0] o = '0;
        for (int i = 0; i < 36; i++)
            if (i < w && i + off < 36) o[i] = v[i + off];
        return o;
    endfunction

    function automatic logic [35:0] ref_ins(input logic [35:0] d, input logic [35:0] s,
                                           input int w, input int off);
        logic [35:0] o = d;
        for (int i = 0; i < w; i++)
            if (i + off < 36) o[i + off] = s[i];
        return o;
    endfunction

    function automatic string tag_of(input logic [3:0] o);
        case (o)
            4'd1: return "R1";
            4'd2: return "R2";
            4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R8";
            4'd8: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic model_step(input logic [3:0] o, input logic a, input logic x,
                              input logic [1:0] c, input logic [35:0] d);
        logic [35:0] cv, nv;
        bit uf = 0;
        int w, off, n;
        cv  = macc[a];
        nv  = cv;
        w   = int'(mctl[c][13:8]);
        off = int'(mctl[c][5:0]);
        case (o)
            4'd1: nv = d;
            4'd2, 4'd3: begin nv = ref_shift(cv, mctl[c][5:0], o == 4'd3); uf = 1; end
            4'd4: begin
                n = ref_norm(cv);
                nv = cv << n;
                mctl[c] = 16'(n);
                mexp = 6'(n);
                uf = 1;
            end
            4'd5: if (w != 0) begin nv = ref_ext(cv, w, off); uf = 1; end
            4'd6: if (w != 0) begin nv = ref_ins(cv, macc[!a], w, off); uf = 1; end
            4'd7: begin nv = maux[x]; maux[x] = cv; end
            4'd8: mctl[c] = d[15:0];
            default: ;
        endcase
        macc[a] = nv;
        mres = nv;
        if (uf) begin
            mz = (nv == '0);
            mn = nv[35];
        end
    endtask

    task automatic issue(input logic [3:0] o, input logic a, input logic x,
                         input logic [1:0] c, input logic [35:0] d, input string tag);
        @(negedge clk);
        compare_all();
        op_valid = 1'b1;
        op = o; acc_sel = a; aux_sel = x; ctl_sel = c; din = d;
        model_step(o, a, x, c, d);
        cur_tag = tag;
        cur_c = c;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 2; i++) begin macc[i] = '0; maux[i] = '0; end
        for (int i = 0; i < 4; i++) mctl[i] = '0;
        mres = '0; mz = 1'b0; mn = 1'b0; mexp = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9 control registers: shift +4, shift -4, field width 8 offset 4, width 0
        issue(4'd8, 0, 0, 2'd0, 36'h0_0000_0004, "R9");
        issue(4'd8, 0, 0, 2'd1, 36'h0_0000_003C, "R9");
        issue(4'd8, 0, 0, 2'd2, 36'h0_0000_0804, "R9");
        issue(4'd8, 0, 0, 2'd3, 36'h0_0000_0000, "R9");
        issue(4'd1, 0, 0, 2'd0, 36'h8_1234_5678, "R1");
        issue(4'd1, 1, 0, 2'd0, 36'h0_0000_00AB, "R1");
        // R2 logical shifts
        issue(4'd2, 0, 0, 2'd0, '0, "R2");
        issue(4'd2, 1, 0, 2'd1, '0, "R2");
        issue(4'd1, 0, 0, 2'd0, 36'h8_0000_0010, "R1");
        issue(4'd2, 0, 0, 2'd1, '0, "R2");
        // R3 arithmetic shifts
        issue(4'd1, 0, 0, 2'd0, 36'h8_0000_0010, "R1");
        issue(4'd3, 0, 0, 2'd1, '0, "R3");
        issue(4'd3, 0, 0, 2'd0, '0, "R3");
        issue(4'd8, 0, 0, 2'd0, 36'h0_0000_0020, "R9");
        issue(4'd1, 0, 0, 2'd0, 36'h9_0000_0000, "R1");
        issue(4'd3, 0, 0, 2'd0, '0, "R3");
        issue(4'd1, 0, 0, 2'd0, 36'h9_0000_0000, "R1");
        issue(4'd2, 0, 0, 2'd0, '0, "R2");
        // R4 normalize: small positive, negative, zero, all ones
        issue(4'd1, 1, 0, 2'd3, 36'h0_0000_0001, "R1");
        issue(4'd4, 1, 0, 2'd3, '0, "R4");
        issue(4'd1, 1, 0, 2'd3, 36'hF_FFFF_FF00, "R1");
        issue(4'd4, 1, 0, 2'd3, '0, "R4");
        issue(4'd1, 1, 0, 2'd3, 36'h0, "R1");
        issue(4'd4, 1, 0, 2'd3, '0, "R4");
        issue(4'd1, 1, 0, 2'd3, 36'hF_FFFF_FFFF, "R1");
        issue(4'd4, 1, 0, 2'd3, '0, "R4");
        issue(4'd8, 0, 0, 2'd3, 36'h0, "R9");
        // R5 / R6 / R7 fields
        issue(4'd1, 0, 0, 2'd2, 36'h0_0000_ABCD, "R1");
        issue(4'd5, 0, 0, 2'd2, '0, "R5");
        issue(4'd1, 1, 0, 2'd2, 36'h0_0000_005A, "R1");
        issue(4'd1, 0, 0, 2'd2, 36'hF_FFFF_FFFF, "R1");
        issue(4'd6, 0, 0, 2'd2, '0, "R6");
        issue(4'd5, 0, 0, 2'd3, '0, "R7");
        issue(4'd6, 0, 0, 2'd3, '0, "R7");
        issue(4'd8, 0, 0, 2'd2, 36'h0_0000_2822, "R9");
        issue(4'd5, 0, 0, 2'd2, '0, "R5");
        issue(4'd8, 0, 0, 2'd2, 36'h0_0000_0820, "R9");
        issue(4'd1, 0, 0, 2'd2, 36'h0, "R1");
        issue(4'd6, 0, 0, 2'd2, '0, "R6");
        // R8 swaps
        issue(4'd1, 0, 0, 2'd0, 36'h1_2345_6789, "R1");
        issue(4'd7, 0, 1, 2'd0, '0, "R8");
        issue(4'd0, 0, 0, 2'd0, '0, "R10");
        issue(4'd7, 0, 1, 2'd0, '0, "R8");
        issue(4'd7, 1, 1, 2'd0, '0, "R8");
        issue(4'd7, 0, 1, 2'd0, '0, "R8");
        issue(4'd15, 0, 0, 2'd0, 36'hF_0000_0000, "R10");
        // mixed random stream
        for (int k = 0; k < 600; k++) begin
            logic [3:0] o;
            o = 4'($urandom_range(0, 9));
            if (o == 4'd9) o = 4'($urandom_range(9, 15));
            issue(o, 1'($urandom), 1'($urandom), 2'($urandom),
                  {4'($urandom), 32'($urandom)}, tag_of(o));
        end
        @(negedge clk);
        compare_all();
        op_valid = 1'b0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule